// File: doc/BRIEF.md
# Residue Channel Multiply-Accumulate Pipeline

This block is one lane of a parallel residue-number arithmetic engine. The lane owns a modulus m = 2^W − c, where c is below 2^(W/2), so m sits just under a power of two. Each clock it can accept two operands below 2^W. It forms their product, or twice their product, and reduces the result modulo m by folding the high half back through c. It can also add a correction term taken from a base-extension step.

The reduced value can pass unchanged or be replaced by its complement against a per-operation constant K. K is typically a precomputed residue of a large multiple of the field prime, which keeps the value nonnegative. The value then feeds one of two accumulators. The first adds its input modulo m. The second subtracts its input modulo m. Either one can be reloaded instead. A per-operation bit chooses which accumulator drives the registered output.

With this, the real and imaginary parts of a quadratic-extension product are collected in a single pass, with no separate subtraction cycles. The pipeline is eight registers deep and accepts one operation per cycle. The operand register file and the sequencer sit outside this block.

Top module: `rns_rower_mac`

## Requirements
- R1: After synchronous reset, `out_o` is 0, `out_valid_o` is 0, and both accumulators hold 0.
- R2: An operation presented with `valid_i` high before clock edge k shows its result on `out_o` with `out_valid_o` high after edge k+7. The block accepts a new operation every cycle.
- R3: With all opcode bits low, the value entering the accumulator stage is |a·b| mod m. Here m = 2^W − c, the operands a and b are any values below 2^W, and c ranges from 1 to 2^(W/2)−1. `c_i` may change only while no operation is in flight.
- R4: With `op_dbl_i` high, the value is |2·a·b| mod m, and `t_i` and `op_corr_i` are ignored.
- R5: With `op_corr_i` high and `op_dbl_i` low, the value is |a·b + t| mod m, where t < m.
- R6: With `op_neg_i` high, the value x from R3–R5 is replaced by |K − x| mod m, where K = `k_i` < m.
- R7: With `op_acc2_i` low, accumulator 1 becomes the value when `op_load_i` is high, and otherwise becomes |acc1 + value| mod m. Accumulator 2 is unchanged.
- R8: With `op_acc2_i` high, accumulator 2 becomes the value when `op_load_i` is high, and otherwise becomes |acc2 − value| mod m. Accumulator 1 is unchanged.
- R9: The output of an operation is accumulator 2 when `op_rd2_i` is high and accumulator 1 when it is low, taken after that operation's own update.
- R10: A cycle with `valid_i` low changes neither accumulator, holds `out_o`, and produces `out_valid_o` low seven edges later.
- R11: Every value written to an accumulator and every valid output is below m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| a_i | input | W | First operand, below 2^W |
| b_i | input | W | Second operand, below 2^W |
| c_i | input | W/2 | Modulus offset c, m = 2^W − c |
| k_i | input | W | Complement constant K, below m |
| t_i | input | W | Correction term, below m |
| op_dbl_i | input | 1 | Double the product |
| op_corr_i | input | 1 | Add the correction term |
| op_neg_i | input | 1 | Replace value by K minus value |
| op_acc2_i | input | 1 | Target accumulator 2 (subtracting) instead of 1 |
| op_load_i | input | 1 | Load the target accumulator instead of combining |
| op_rd2_i | input | 1 | Output accumulator 2 instead of 1 |
| out_valid_o | output | 1 | Output carries a fresh result |
| out_o | output | W | Selected accumulator value |

## Verification
Each operation's result is due exactly eight falling edges after the falling edge at which the bench drives it. The operation is captured at the next rising edge, and `out_o` is updated at the eighth rising edge after that. The bench drives at one falling edge and, at each later falling edge, first compares `out_o` and `out_valid_o` with the prediction it stored eight steps earlier. Idle cycles predict an unchanged output with the valid flag low. The predictions come from a sequential model that applies the operations in issue order, using wide-integer remainder arithmetic. Changes of c only happen after at least ten idle cycles, so no operation in flight sees two moduli.

// File: rtl/rch_pkg.sv
package rch_pkg;
  typedef struct packed {
    logic dbl;
    logic corr;
    logic neg;
    logic acc2;
    logic load;
    logic rd2;
  } rch_op_t;
endpackage

// File: rtl/rch_fold.sv
module rch_fold
  import rch_pkg::*;
#(
  parameter int W = 34
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  rch_op_t             op_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic [W-1:0]        t_i,
  input  logic [W-1:0]        k_i,
  input  logic [W/2-1:0]      c_i,
  input  logic [W-1:0]        m_i,
  output logic                v_o,
  output rch_op_t             op_o,
  output logic [W-1:0]        x_o,
  output logic [W-1:0]        k_o
);
  localparam int CW  = W / 2;
  localparam int HCW = W + CW + 1;
  localparam int NST = 5;

  logic [W-1:0] c_ext;
  assign c_ext = {{(W-CW){1'b0}}, c_i};

  function automatic logic [W-1:0] red1(input logic [W:0] x);
    logic [W:0] y;
    y = {1'b0, x[W-1:0]} + (x[W] ? {1'b0, c_ext} : '0);
    if (y >= {1'b0, m_i}) y = y - {1'b0, m_i};
    return y[W-1:0];
  endfunction

  function automatic logic [W-1:0] madd(input logic [W-1:0] p, input logic [W-1:0] q);
    return red1({1'b0, p} + {1'b0, q});
  endfunction

  // control and constant travel alongside the data
  logic    v_q  [NST];
  rch_op_t op_q [NST];
  logic [W-1:0] k_q [NST];
  logic [W-1:0] t_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NST; s++) v_q[s] <= 1'b0;
    end else begin
      v_q[0] <= v_i;
      for (int s = 1; s < NST; s++) v_q[s] <= v_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    op_q[0] <= op_i;
    k_q[0]  <= k_i;
    t_q     <= t_i;
    for (int s = 1; s < NST; s++) begin
      op_q[s] <= op_q[s-1];
      k_q[s]  <= k_q[s-1];
    end
  end

  // stage 1: full product
  logic [2*W-1:0] prod_q;
  always_ff @(posedge clk) prod_q <= {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};

  // stage 2: high half times c (or 2c); low half plus addend
  logic [CW:0]    fac;
  logic [HCW-1:0] hc_n, hc_q;
  logic [W-1:0]   addend, s2_q;
  assign fac    = op_q[0].dbl ? {c_i, 1'b0} : {1'b0, c_i};
  assign hc_n   = {{(CW+1){1'b0}}, prod_q[2*W-1:W]} * {{W{1'b0}}, fac};
  assign addend = op_q[0].dbl ? prod_q[W-1:0] : (op_q[0].corr ? t_q : '0);
  always_ff @(posedge clk) begin
    hc_q <= hc_n;
    s2_q <= madd(prod_q[W-1:0], addend);
  end

  // stage 3: second fold product; merge low part of first fold
  logic [W:0]   hc2_n, hc2_q;
  logic [W-1:0] s3_q;
  assign hc2_n = {{CW{1'b0}}, hc_q[HCW-1:W]} * {{(CW+1){1'b0}}, c_i};
  always_ff @(posedge clk) begin
    hc2_q <= hc2_n;
    s3_q  <= madd(hc_q[W-1:0], s2_q);
  end

  // stage 4: bring second fold below m
  logic [W-1:0] r4_q, s4_q;
  always_ff @(posedge clk) begin
    r4_q <= red1(hc2_q);
    s4_q <= s3_q;
  end

  // stage 5: final residue
  logic [W-1:0] x_q;
  always_ff @(posedge clk) x_q <= madd(r4_q, s4_q);

  assign v_o  = v_q[NST-1];
  assign op_o = op_q[NST-1];
  assign k_o  = k_q[NST-1];
  assign x_o  = x_q;

  AST_FOLD_BELOW_M: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (x_o < m_i)); // R3
  AST_FOLD_PARTIAL_BELOW_M: assert property (@(posedge clk) disable iff (rst)
    v_q[3] |-> (r4_q < m_i) && (s4_q < m_i)); // R11
endmodule

// File: rtl/rch_negate.sv
module rch_negate
  import rch_pkg::*;
#(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  rch_op_t      op_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] k_i,
  input  logic [W/2-1:0] c_i,
  input  logic [W-1:0] m_i,
  output logic         v_o,
  output rch_op_t      op_o,
  output logic [W-1:0] y_o
);
  localparam int CW = W / 2;

  logic [W-1:0] c_ext;
  assign c_ext = {{(W-CW){1'b0}}, c_i};

  function automatic logic [W-1:0] red1(input logic [W:0] x);
    logic [W:0] y;
    y = {1'b0, x[W-1:0]} + (x[W] ? {1'b0, c_ext} : '0);
    if (y >= {1'b0, m_i}) y = y - {1'b0, m_i};
    return y[W-1:0];
  endfunction

  function automatic logic [W-1:0] msub(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [W:0] d;
    if (p >= q) d = {1'b0, p} - {1'b0, q};
    else        d = {1'b0, p} + {1'b0, m_i} - {1'b0, q};
    return d[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    op_o <= op_i;
    y_o  <= op_i.neg ? msub(k_i, x_i) : x_i;
  end

  AST_NEG_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    v_i && op_i.neg |=> red1({1'b0, y_o} + {1'b0, $past(x_i)}) == red1({1'b0, $past(k_i)})); // R6
  AST_NEG_BELOW_M: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (y_o < m_i)); // R11
endmodule

// File: rtl/rch_accum.sv
module rch_accum
  import rch_pkg::*;
#(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  rch_op_t      op_i,
  input  logic [W-1:0] y_i,
  input  logic [W/2-1:0] c_i,
  input  logic [W-1:0] m_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_o
);
  localparam int CW = W / 2;

  logic [W-1:0] c_ext;
  assign c_ext = {{(W-CW){1'b0}}, c_i};

  function automatic logic [W-1:0] red1(input logic [W:0] x);
    logic [W:0] y;
    y = {1'b0, x[W-1:0]} + (x[W] ? {1'b0, c_ext} : '0);
    if (y >= {1'b0, m_i}) y = y - {1'b0, m_i};
    return y[W-1:0];
  endfunction

  function automatic logic [W-1:0] msub(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [W:0] d;
    if (p >= q) d = {1'b0, p} - {1'b0, q};
    else        d = {1'b0, p} + {1'b0, m_i} - {1'b0, q};
    return d[W-1:0];
  endfunction

  logic [W-1:0] acc1_q, acc2_q;
  logic         v7_q, rd2_q;

  // stage 7: accumulator update
  always_ff @(posedge clk) begin
    if (rst) begin
      acc1_q <= '0;
      acc2_q <= '0;
      v7_q   <= 1'b0;
      rd2_q  <= 1'b0;
    end else begin
      v7_q  <= v_i;
      rd2_q <= op_i.rd2;
      if (v_i && !op_i.acc2)
        acc1_q <= op_i.load ? y_i : red1({1'b0, acc1_q} + {1'b0, y_i});
      if (v_i && op_i.acc2)
        acc2_q <= op_i.load ? y_i : msub(acc2_q, y_i);
    end
  end

  // stage 8: registered output select
  always_ff @(posedge clk) begin
    if (rst) begin
      out_o       <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= v7_q;
      if (v7_q) out_o <= rd2_q ? acc2_q : acc1_q;
    end
  end

  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !v_i |=> $stable(acc1_q) && $stable(acc2_q)); // R10
  AST_ACC1_ONLY: assert property (@(posedge clk) disable iff (rst)
    v_i && !op_i.acc2 |=> $stable(acc2_q)); // R7
  AST_ACC2_ONLY: assert property (@(posedge clk) disable iff (rst)
    v_i && op_i.acc2 |=> $stable(acc1_q)); // R8
  AST_ACC1_BELOW_M: assert property (@(posedge clk) disable iff (rst)
    v_i && !op_i.acc2 |=> (acc1_q < m_i)); // R11
  AST_OUT_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> $past(v7_q)); // R2
  AST_OUT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !v7_q |=> $stable(out_o) && !out_valid_o); // R10
endmodule

// File: rtl/rns_rower_mac.sv
module rns_rower_mac
  import rch_pkg::*;
#(
  parameter int W = 34
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W/2-1:0] c_i,
  input  logic [W-1:0]   k_i,
  input  logic [W-1:0]   t_i,
  input  logic           op_dbl_i,
  input  logic           op_corr_i,
  input  logic           op_neg_i,
  input  logic           op_acc2_i,
  input  logic           op_load_i,
  input  logic           op_rd2_i,
  output logic           out_valid_o,
  output logic [W-1:0]   out_o
);
  localparam int CW = W / 2;

  logic [W-1:0] m;
  assign m = '0 - {{(W-CW){1'b0}}, c_i};

  rch_op_t op_in;
  assign op_in = '{dbl: op_dbl_i, corr: op_corr_i, neg: op_neg_i,
                   acc2: op_acc2_i, load: op_load_i, rd2: op_rd2_i};

  logic         v5, v6;
  rch_op_t      op5, op6;
  logic [W-1:0] x5, k5, y6;

  rch_fold #(.W(W)) u_fold (
    .clk(clk), .rst(rst), .v_i(valid_i), .op_i(op_in),
    .a_i(a_i), .b_i(b_i), .t_i(t_i), .k_i(k_i), .c_i(c_i), .m_i(m),
    .v_o(v5), .op_o(op5), .x_o(x5), .k_o(k5)
  );

  rch_negate #(.W(W)) u_neg (
    .clk(clk), .rst(rst), .v_i(v5), .op_i(op5), .x_i(x5), .k_i(k5),
    .c_i(c_i), .m_i(m), .v_o(v6), .op_o(op6), .y_o(y6)
  );

  rch_accum #(.W(W)) u_acc (
    .clk(clk), .rst(rst), .v_i(v6), .op_i(op6), .y_i(y6),
    .c_i(c_i), .m_i(m), .out_valid_o(out_valid_o), .out_o(out_o)
  );

  AST_OUT_BELOW_M: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (out_o < m)); // R11
endmodule

// File: tb/tb_rns_rower_mac.sv
`timescale 1ns/1ps
module tb_rns_rower_mac;
  localparam int W    = 34;
  localparam int CW   = W / 2;
  localparam int LAT  = 8;
  localparam int NCYC = 4096;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, valid_i, dbl, corr, neg, asel, load, rd2, out_valid_o;
  logic [W-1:0] a_i, b_i, k_i, t_i, out_o;
  logic [CW-1:0] c_i;

  rns_rower_mac #(.W(W)) dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .k_i(k_i), .t_i(t_i), .op_dbl_i(dbl), .op_corr_i(corr), .op_neg_i(neg),
    .op_acc2_i(asel), .op_load_i(load), .op_rd2_i(rd2),
    .out_valid_o(out_valid_o), .out_o(out_o)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [W-1:0] exp_out [NCYC];
  logic         exp_v   [NCYC];
  string        exp_req [NCYC];
  logic [W-1:0] ma1 = '0, ma2 = '0, mlast = '0, mm;

  function automatic logic [W-1:0] mdl_val(input logic [W-1:0] a, b, k, t,
                                           input logic d, cr, ng, input logic [W-1:0] md);
    logic [127:0] p, x;
    p = 128'(a) * 128'(b);
    if (d) p = p * 2;
    else if (cr) p = p + 128'(t);
    x = p % 128'(md);
    if (ng) x = (128'(k) + 128'(md) - x) % 128'(md);
    return x[W-1:0];
  endfunction

  task automatic check_now();
    logic ev; logic [W-1:0] eo; string rq;
    if (cyc < LAT) begin ev = 1'b0; eo = '0; rq = "R1"; end
    else begin ev = exp_v[cyc-LAT]; eo = exp_out[cyc-LAT]; rq = exp_req[cyc-LAT]; end
    total++;
    if (out_valid_o !== ev) begin
      bad++;
      $display("FAIL R2 valid at step %0d: got %0b want %0b", cyc, out_valid_o, ev);
    end
    total++;
    if (out_o !== eo) begin
      bad++;
      $display("FAIL %s out at step %0d: got %h want %h", rq, cyc, out_o, eo);
    end
    if (ev) begin
      total++;
      if (!(out_o < mm)) begin
        bad++;
        $display("FAIL R11 out %h not below m %h", out_o, mm);
      end
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] a, b, k, t,
                      input logic d, cr, ng, as, ld, r2, input string rq);
    logic [W-1:0] y;
    @(negedge clk);
    check_now();
    valid_i = v; a_i = a; b_i = b; k_i = k; t_i = t;
    dbl = d; corr = cr; neg = ng; asel = as; load = ld; rd2 = r2;
    if (v) begin
      y = mdl_val(a, b, k, t, d, cr, ng, mm);
      if (!as) ma1 = ld ? y : W'((65'(ma1) + 65'(y)) % 65'(mm));
      else     ma2 = ld ? y : W'((65'(ma2) + 65'(mm) - 65'(y)) % 65'(mm));
      mlast = r2 ? ma2 : ma1;
      exp_req[cyc] = rq;
    end else begin
      exp_req[cyc] = "R10";
    end
    exp_v[cyc]   = v;
    exp_out[cyc] = mlast;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, '0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  function automatic logic [W-1:0] rnd_op();
    logic [63:0] r;
    int sel;
    sel = int'($urandom % 8);
    r = {$urandom, $urandom};
    if (sel == 0) return '1;
    if (sel == 1) return mm - 1;
    if (sel == 2) return '0;
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd_below_m();
    logic [63:0] r;
    r = {$urandom, $urandom};
    return W'(r % 64'(mm));
  endfunction

  task automatic set_mod(input logic [CW-1:0] c);
    idle(10);
    c_i = c;
    mm = W'((65'(1) << W) - 65'(c));
  endtask

  task automatic segment(input logic [CW-1:0] c, input int n);
    logic [W-1:0] a, b, k, t;
    logic d, cr, ng, as, ld, r2;
    string rq;
    set_mod(c);
    // reload both accumulators under the new modulus
    step(1'b1, rnd_op(), rnd_op(), '0, '0, 0, 0, 0, 0, 1, 0, "R7");
    step(1'b1, rnd_op(), rnd_op(), '0, '0, 0, 0, 0, 1, 1, 1, "R8");
    // directed corners: largest operands, largest correction, complement of zero
    step(1'b1, '1, '1, '0, '0, 0, 0, 0, 0, 1, 0, "R3");
    step(1'b1, '1, '1, '0, mm - 1, 1, 1, 0, 0, 1, 0, "R4");
    step(1'b1, '1, mm - 1, '0, mm - 1, 0, 1, 0, 0, 1, 0, "R5");
    step(1'b1, '0, '1, '0, '0, 0, 0, 1, 0, 1, 0, "R6");
    step(1'b1, '1, '1, mm - 1, '0, 0, 0, 1, 1, 0, 1, "R6");
    for (int i = 0; i < n; i++) begin
      a = rnd_op(); b = rnd_op(); k = rnd_below_m(); t = rnd_below_m();
      d = $urandom % 4 == 0; cr = $urandom % 2 == 0; ng = $urandom % 3 == 0;
      as = $urandom % 2 == 0; ld = $urandom % 4 == 0; r2 = $urandom % 2 == 0;
      rq = ng ? "R6" : d ? "R4" : cr ? "R5" : as ? "R8" : r2 ? "R9" : "R7";
      step($urandom % 8 != 0, a, b, k, t, d, cr, ng, as, ld, r2, rq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired at step %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; valid_i = 1'b0; a_i = '0; b_i = '0; k_i = '0; t_i = '0;
    dbl = 0; corr = 0; neg = 0; asel = 0; load = 0; rd2 = 0;
    c_i = CW'(3); mm = W'((65'(1) << W) - 65'(3));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: accumulators read back as zero after reset (adding and subtracting zero)
    step(1'b1, '0, '0, '0, '0, 0, 0, 0, 0, 0, 0, "R1");
    step(1'b1, '0, '0, '0, '0, 0, 0, 0, 1, 0, 1, "R1");
    // R2: back-to-back issue
    step(1'b1, 34'd5, 34'd7, '0, '0, 0, 0, 0, 0, 1, 0, "R2");
    step(1'b1, 34'd11, 34'd13, '0, '0, 0, 0, 0, 0, 0, 0, "R2");
    // R9: same state read from both sides
    step(1'b1, 34'd2, 34'd3, '0, '0, 0, 0, 0, 1, 1, 0, "R9");
    step(1'b1, '0, '0, '0, '0, 0, 0, 0, 0, 0, 1, "R9");
    segment(CW'(3), 700);
    segment(CW'(1), 700);
    segment({CW{1'b1}}, 700);
    segment(CW'(17'h12345), 700);
    idle(LAT + 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule